// File: doc/BRIEF.md
# Error Status and Header Logger

This block gathers single-cycle error strobes from a link controller into two sticky status words: one for correctable errors and one for uncorrectable errors. Each class of report has its own enable mask (correctable, uncorrectable non-fatal, uncorrectable fatal). When a status bit becomes set and its class mask enables it, the matching report output pulses for one cycle. Management logic reads the status words through a small register port. A read of a status word returns its contents and clears them.

When the first uncorrectable error arrives, the 128-bit header presented with it is stored and then frozen. Later errors cannot overwrite it. The log is released once the status bit of the error that captured it has really gone back to zero. Two control bits, one for end-to-end CRC generation and one for end-to-end CRC checking, are held here and driven out to the datapath.

Top module: `errlog_top`

## Requirements
- R1: After reset, both status words, all three masks, the control bits, the header-held flag and the three report outputs are zero.
- R2: An uncorrectable strobe sets a status bit only at positions 4, 12, 13, 14, 15, 16, 17, 18, 19, 20, 22 and 24 (value mask 0x015FF010). Strobes at any other position leave the status unchanged.
- R3: A correctable strobe sets a status bit only at positions 0, 6, 7, 8, 12, 13 and 14 (value mask 0x71C1). Strobes at any other position leave the status unchanged.
- R4: When `reg_rd` is high, `reg_rdata` shows the selected register in the same cycle. Address 0 is the correctable status and address 1 is the uncorrectable status. A read of address 0 or 1 clears that status word at the following clock edge.
- R5: A strobe that arrives in the same cycle as a clearing read of its status word leaves its bit set after the clear.
- R6: `rpt_corr` pulses high for one cycle, in the cycle after the edge that newly sets a correctable bit enabled in the correctable mask (address 2). With a mask of 0, no pulse occurs, but the status bit is still set.
- R7: Each newly set uncorrectable bit is tested against two masks on its own: the non-fatal mask (address 3) drives `rpt_nonfatal` and the fatal mask (address 4) drives `rpt_fatal`. Each output pulses in the cycle after the setting edge.
- R8: A strobe on a status bit that is already set produces no report pulse.
- R9: The first uncorrectable strobe at an implemented position stores `hdr_in` and raises `hdr_held`. Addresses 8 to 11 read header dwords 0 to 3, where dword 0 is `hdr_in[31:0]`. Later strobes do not change the stored header while it is held.
- R10: The stored header stays frozen until the lowest-indexed status bit of the capturing strobe is cleared. If a clearing read coincides with a new strobe on that bit, the header stays held.
- R11: Control register address 5 holds bit 0 (CRC generation enable) and bit 1 (CRC check enable). It drives `ecrc_gen_en` and `ecrc_chk_en` from the edge after the write, and it reads back.
- R12: Mask registers written through the port read back their written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| corr_evt | input | 16 | Correctable error strobes, one bit per error kind |
| uncorr_evt | input | 32 | Uncorrectable error strobes, one bit per error kind |
| hdr_in | input | 128 | Header of the TLP that goes with an uncorrectable strobe |
| reg_addr | input | 4 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears a status word it reads) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid while reg_rd is high |
| rpt_corr | output | 1 | Correctable report pulse |
| rpt_nonfatal | output | 1 | Uncorrectable non-fatal report pulse |
| rpt_fatal | output | 1 | Uncorrectable fatal report pulse |
| hdr_held | output | 1 | A header is logged and frozen |
| ecrc_gen_en | output | 1 | End-to-end CRC generation enable |
| ecrc_chk_en | output | 1 | End-to-end CRC check enable |

## Verification
The hardest case to reach is a clearing read of the uncorrectable status that lands in the same cycle as a fresh strobe on the very bit that owns the frozen header. The bench first stores one header, then offers a second strobe with a different header, which must be ignored. Next it issues the read of address 1 while strobing the owning bit again. It then checks that the status bit, the held flag and the old header all survive, and that only a later, quiet read frees the log for a third capture.

// File: rtl/errlog_pkg.sv
package errlog_pkg;
  localparam int CW     = 16;
  localparam int UW     = 32;
  localparam int DW     = 32;
  localparam int HDR_DW = 4;
  localparam int HW     = DW * HDR_DW;
  localparam int AW     = 4;

  localparam logic [CW-1:0] CORR_IMPL = 16'h71C1;
  localparam logic [UW-1:0] UNC_IMPL  = 32'h015F_F010;

  localparam logic [AW-1:0] A_CSTAT = 4'd0;
  localparam logic [AW-1:0] A_USTAT = 4'd1;
  localparam logic [AW-1:0] A_CMSK  = 4'd2;
  localparam logic [AW-1:0] A_NFMSK = 4'd3;
  localparam logic [AW-1:0] A_FMSK  = 4'd4;
  localparam logic [AW-1:0] A_CTRL  = 4'd5;

  typedef struct packed {
    logic chk;
    logic gen;
  } crc_ctl_t;
endpackage

// File: rtl/errlog_status.sv
module errlog_status #(
  parameter int W = 16,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         clr_rd,
  output logic [W-1:0] stat,
  output logic [W-1:0] fresh
);
  logic [W-1:0] evt_v;
  logic [W-1:0] stat_d;
  logic         stat_en;

  always_comb begin
    evt_v   = evt & IMPL;
    fresh   = evt_v & ~stat;
    stat_d  = clr_rd ? evt_v : (stat | evt_v);
    stat_en = clr_rd | (|evt_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat <= '0;
    else if (stat_en) stat <= stat_d;
  end
endmodule

// File: rtl/errlog_report.sv
module errlog_report #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] fresh,
  input  logic [W-1:0] mask,
  output logic         pulse
);
  logic pulse_d;

  always_comb pulse_d = |(fresh & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= pulse_d;
  end
endmodule

// File: rtl/errlog_hdr.sv
module errlog_hdr #(
  parameter int DW     = 32,
  parameter int HDR_DW = 4,
  parameter int UW     = 32,
  localparam int HW    = DW * HDR_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] hdr_in,
  input  logic [UW-1:0] evt_v,
  input  logic          clr_rd,
  output logic          held,
  output logic [HW-1:0] log_q
);
  logic [UW-1:0] owner;
  logic [UW-1:0] owner_d;
  logic          release_now;
  logic          cap;
  logic          held_d;

  always_comb begin
    release_now = held & clr_rd & (|(owner & ~evt_v));
    cap         = ~(held & ~release_now) & (|evt_v);
    owner_d     = evt_v & (~evt_v + 1'b1);
    held_d      = cap | (held & ~release_now);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held  <= 1'b0;
      owner <= '0;
    end else begin
      held <= held_d;
      if (cap) owner <= owner_d;
    end
  end

  for (genvar g = 0; g < HDR_DW; g++) begin : g_dw
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   log_q[g*DW +: DW] <= '0;
      else if (cap) log_q[g*DW +: DW] <= hdr_in[g*DW +: DW];
    end
  end
endmodule

// File: rtl/errlog_cfg.sv
module errlog_cfg
  import errlog_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [CW-1:0] cmask,
  output logic [UW-1:0] nfmask,
  output logic [UW-1:0] fmask,
  output crc_ctl_t      ctl
);
  logic wr_c, wr_nf, wr_f, wr_ctl;

  always_comb begin
    wr_c   = wr && (addr == A_CMSK);
    wr_nf  = wr && (addr == A_NFMSK);
    wr_f   = wr && (addr == A_FMSK);
    wr_ctl = wr && (addr == A_CTRL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmask  <= '0;
      nfmask <= '0;
      fmask  <= '0;
      ctl    <= '0;
    end else begin
      if (wr_c)   cmask  <= wdata[CW-1:0];
      if (wr_nf)  nfmask <= wdata[UW-1:0];
      if (wr_f)   fmask  <= wdata[UW-1:0];
      if (wr_ctl) ctl    <= crc_ctl_t'(wdata[1:0]);
    end
  end
endmodule

// File: rtl/errlog_top.sv
module errlog_top
  import errlog_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] corr_evt,
  input  logic [UW-1:0] uncorr_evt,
  input  logic [HW-1:0] hdr_in,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          rpt_corr,
  output logic          rpt_nonfatal,
  output logic          rpt_fatal,
  output logic          hdr_held,
  output logic          ecrc_gen_en,
  output logic          ecrc_chk_en
);
  logic [CW-1:0] stat_c, fresh_c, cmask_q;
  logic [UW-1:0] stat_u, fresh_u, nfmask_q, fmask_q;
  logic [HW-1:0] hdr_log;
  logic          cclr, uclr;
  crc_ctl_t      ctl_q;

  always_comb begin
    cclr = reg_rd && (reg_addr == A_CSTAT);
    uclr = reg_rd && (reg_addr == A_USTAT);
  end

  errlog_status #(.W(CW), .IMPL(CORR_IMPL)) u_cstat (
    .clk(clk), .rst_n(rst_n), .evt(corr_evt), .clr_rd(cclr),
    .stat(stat_c), .fresh(fresh_c));

  errlog_status #(.W(UW), .IMPL(UNC_IMPL)) u_ustat (
    .clk(clk), .rst_n(rst_n), .evt(uncorr_evt), .clr_rd(uclr),
    .stat(stat_u), .fresh(fresh_u));

  errlog_report #(.W(CW)) u_rpt_c (
    .clk(clk), .rst_n(rst_n), .fresh(fresh_c), .mask(cmask_q), .pulse(rpt_corr));
  errlog_report #(.W(UW)) u_rpt_nf (
    .clk(clk), .rst_n(rst_n), .fresh(fresh_u), .mask(nfmask_q), .pulse(rpt_nonfatal));
  errlog_report #(.W(UW)) u_rpt_f (
    .clk(clk), .rst_n(rst_n), .fresh(fresh_u), .mask(fmask_q), .pulse(rpt_fatal));

  errlog_hdr #(.DW(DW), .HDR_DW(HDR_DW), .UW(UW)) u_hdr (
    .clk(clk), .rst_n(rst_n), .hdr_in(hdr_in), .evt_v(uncorr_evt & UNC_IMPL),
    .clr_rd(uclr), .held(hdr_held), .log_q(hdr_log));

  errlog_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .cmask(cmask_q), .nfmask(nfmask_q), .fmask(fmask_q), .ctl(ctl_q));

  always_comb begin
    ecrc_gen_en = ctl_q.gen;
    ecrc_chk_en = ctl_q.chk;
    reg_rdata   = '0;
    if (reg_rd) begin
      if (reg_addr[3]) begin
        reg_rdata = hdr_log[reg_addr[1:0]*DW +: DW];
      end else begin
        case (reg_addr)
          A_CSTAT: reg_rdata = {{(DW-CW){1'b0}}, stat_c};
          A_USTAT: reg_rdata = stat_u;
          A_CMSK:  reg_rdata = {{(DW-CW){1'b0}}, cmask_q};
          A_NFMSK: reg_rdata = nfmask_q;
          A_FMSK:  reg_rdata = fmask_q;
          A_CTRL:  reg_rdata = {{(DW-2){1'b0}}, ctl_q};
          default: reg_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/errlog_chk.sv
module errlog_chk
  import errlog_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] corr_evt,
  input logic [UW-1:0] uncorr_evt,
  input logic [CW-1:0] corr_mask,
  input logic [UW-1:0] fatal_mask,
  input logic          rpt_corr,
  input logic          rpt_fatal,
  input logic          uclr,
  input logic [UW-1:0] stat_u,
  input logic          hdr_held,
  input logic [HW-1:0] hdr_log
);
  AST_CORR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_corr |-> $past(|(corr_evt & corr_mask))); // R6
  AST_FATAL_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_fatal |-> $past(|(uncorr_evt & fatal_mask))); // R7
  AST_UNC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(uclr) |-> ((stat_u & $past(stat_u)) == $past(stat_u))); // R5
  AST_HDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_held && $past(hdr_held)) |-> $stable(hdr_log)); // R9
  AST_UNC_ONLY_IMPL: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_u & ~$past(stat_u)) & ~UNC_IMPL) == '0); // R2
endmodule

bind errlog_top errlog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .corr_evt(corr_evt), .uncorr_evt(uncorr_evt),
  .corr_mask(cmask_q), .fatal_mask(fmask_q), .rpt_corr(rpt_corr),
  .rpt_fatal(rpt_fatal), .uclr(uclr), .stat_u(stat_u),
  .hdr_held(hdr_held), .hdr_log(hdr_log));

// File: tb/errlog_top_tb.sv
module errlog_top_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [15:0]  corr_evt;
  logic [31:0]  uncorr_evt;
  logic [127:0] hdr_in;
  logic [3:0]   reg_addr;
  logic         reg_wr, reg_rd;
  logic [31:0]  reg_wdata, reg_rdata;
  logic         rpt_corr, rpt_nonfatal, rpt_fatal, hdr_held, ecrc_gen_en, ecrc_chk_en;
  int           n_chk = 0;
  int           n_bad = 0;
  bit           done = 1'b0;

  always #5 clk = ~clk;

  errlog_top u_dut (.*);

  // {corr_evt, uncorr_evt, exp corr status, exp uncorr status, exp {corr,nonfatal,fatal}}
  localparam logic [98:0] VEC [8] = '{
    {16'h0001, 32'h0000_0000, 16'h0001, 32'h0000_0000, 3'b100},
    {16'hFFFF, 32'h0000_0000, 16'h71C1, 32'h0000_0000, 3'b100},
    {16'h0002, 32'h0000_0000, 16'h0000, 32'h0000_0000, 3'b000},
    {16'h0000, 32'hFFFF_FFFF, 16'h0000, 32'h015F_F010, 3'b011},
    {16'h0000, 32'h0000_1000, 16'h0000, 32'h0000_1000, 3'b010},
    {16'h0000, 32'h0000_0010, 16'h0000, 32'h0000_0010, 3'b001},
    {16'h0000, 32'h0002_0000, 16'h0000, 32'h0002_0000, 3'b000},
    {16'h0000, 32'h0000_0001, 16'h0000, 32'h0000_0000, 3'b000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a; reg_rd = 1'b1;
    #1 chk(tag, reg_rdata, exp);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic ev(input logic [15:0] c, input logic [31:0] u);
    corr_evt = c; uncorr_evt = u;
    @(negedge clk);
    corr_evt = '0; uncorr_evt = '0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; corr_evt = '0; uncorr_evt = '0; hdr_in = '0;
    reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 reports", {29'd0, rpt_corr, rpt_nonfatal, rpt_fatal}, 32'd0);
    chk("R1 held/ctrl", {29'd0, hdr_held, ecrc_gen_en, ecrc_chk_en}, 32'd0);
    rd(4'd0, 32'd0, "R1 corr status");
    rd(4'd1, 32'd0, "R1 uncorr status");
    rd(4'd4, 32'd0, "R1 fatal mask");

    wr(4'd2, 32'h0000_FFFF);
    wr(4'd3, 32'h0000_F000);
    wr(4'd4, 32'h0000_0010);

    // vector table: R2 R3 R4 R6 R7
    for (int i = 0; i < 8; i++) begin
      ev(VEC[i][98:83], VEC[i][82:51]);
      chk($sformatf("R6/R7 pulses v%0d", i), {29'd0, rpt_corr, rpt_nonfatal, rpt_fatal},
          {29'd0, VEC[i][2:0]});
      rd(4'd0, {16'd0, VEC[i][50:35]}, $sformatf("R3/R4 corr v%0d", i));
      rd(4'd1, VEC[i][34:3], $sformatf("R2/R4 uncorr v%0d", i));
    end

    // R8 repeat strobe on a set bit, R5 set during clear
    ev(16'h0001, '0);
    chk("R6 first pulse", {31'd0, rpt_corr}, 32'd1);
    reg_addr = 4'd0; reg_rd = 1'b1; corr_evt = 16'h0001;
    #1 chk("R4 same-cycle read", reg_rdata, 32'd1);
    @(negedge clk);
    reg_rd = 1'b0; corr_evt = '0;
    chk("R8 no pulse on set bit", {31'd0, rpt_corr}, 32'd0);
    rd(4'd0, 32'd1, "R5 bit survives clear");
    rd(4'd0, 32'd0, "R4 cleared");

    // R6 mask zero
    wr(4'd2, 32'd0);
    ev(16'h0040, '0);
    chk("R6 masked no pulse", {31'd0, rpt_corr}, 32'd0);
    rd(4'd0, 32'h40, "R6 status still set");

    // R9 R10 header
    hdr_in = 128'h44444444_33333333_22222222_11111111;
    ev('0, 32'h0000_4000);
    chk("R7 nonfatal only", {30'd0, rpt_nonfatal, rpt_fatal}, 32'b10);
    chk("R9 held", {31'd0, hdr_held}, 32'd1);
    rd(4'd8,  32'h11111111, "R9 dword0");
    rd(4'd11, 32'h44444444, "R9 dword3");
    hdr_in = 128'hBBBB_BBBB_BBBB_BBBB_BBBB_BBBB_BBBB_BBBB;
    ev('0, 32'h0000_1000);
    rd(4'd8, 32'h11111111, "R9 not overwritten");
    reg_addr = 4'd1; reg_rd = 1'b1; uncorr_evt = 32'h0000_4000;
    #1 chk("R4 uncorr read", reg_rdata, 32'h0000_5000);
    @(negedge clk);
    reg_rd = 1'b0; uncorr_evt = '0;
    chk("R10 held through re-set", {31'd0, hdr_held}, 32'd1);
    rd(4'd8, 32'h11111111, "R10 header kept");
    rd(4'd1, 32'h0000_4000, "R5 owner bit kept");
    chk("R10 released", {31'd0, hdr_held}, 32'd0);
    hdr_in = 128'hDDDDDDDD_CCCCCCCC_BBBBBBBB_CAFE0001;
    ev('0, 32'h0010_0000);
    chk("R9 recapture held", {31'd0, hdr_held}, 32'd1);
    rd(4'd8, 32'hCAFE0001, "R9 new dword0");

    // R11 R12
    wr(4'd5, 32'd3);
    chk("R11 both on", {30'd0, ecrc_chk_en, ecrc_gen_en}, 32'b11);
    wr(4'd5, 32'd2);
    chk("R11 chk only", {30'd0, ecrc_chk_en, ecrc_gen_en}, 32'b10);
    rd(4'd5, 32'd2, "R11 readback");
    rd(4'd3, 32'h0000_F000, "R12 nonfatal mask");
    rd(4'd4, 32'h0000_0010, "R12 fatal mask");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule